// File: doc/BRIEF.md
# Programmable Linear Feedback Sequence Generator

This block produces a pseudo-random bit stream from a linear feedback shift register. The length of the register, its feedback taps and its starting value can all be changed at run time. The register can be built in either of two ways, picked per cycle by an input. In the shift-then-feed form, one parity bit of the tapped bits enters at the bottom. In the shift-then-xor form, the tap word is applied across the register whenever a one leaves the top.

The register advances in one of two ways while the enable input is high. In continuous mode it moves once per clock. In single-step mode it moves once for each rising edge of a strobe input. This lets the generator follow other logic cycle by cycle or run under a slow external pace. Each advance records the bit leaving the top of the active register on a serial output. The whole register is visible at all times on a parallel output.

Top module: `lfsr_seq`

## Requirements
- R1: Synchronous active-low reset. During reset the tap word takes the default value DFLT_POLY (64'hD800_0000_0000_0000). The register takes the default seed DFLT_SEED (value 1), masked to the active length. The serial output is 0. The step-edge history is cleared.
- R2: With `galois_sel` = 0, an advance forms a feedback bit. This bit is the XOR of the register bits whose tap-word bit is 1 and which lie inside the active length. The register then shifts one place toward the MSB and the feedback bit enters bit 0.
- R3: With `galois_sel` = 1, an advance shifts the register one place toward the MSB with a 0 entering bit 0. If the bit at position length-1 was 1 before the advance, the tap word is XORed into the result. Bits outside the active length are excluded.
- R4: With `step_mode` = 0 and `en` = 1, the register advances on every clock.
- R5: With `en` = 0 the register does not advance and the serial output holds, whatever `step_mode` and `step_strobe` do.
- R6: With `step_mode` = 1, the register advances exactly once per 0-to-1 change of `step_strobe` seen while `en` = 1. A strobe held high gives one advance.
- R7: `seed_load` = 1 loads the seed into the register on the next clock. The seed is the default seed when `seed_dflt` = 1 and `seed_in` otherwise, masked to the active length. A masked value of zero is replaced by 1. A load takes priority over an advance, ignores `en`, and leaves the serial output unchanged.
- R8: `poly_load` = 1 replaces the tap word on the next clock. The new word is DFLT_POLY when `poly_dflt` = 1 and `poly_in` otherwise. An advance in the same cycle still uses the old word. Without `poly_load` the tap word is kept.
- R9: The active length is `len_cfg`, held between 2 and MAX_W (values below 2 act as 2, values above MAX_W act as MAX_W). Register bits at or above the active length read as zero from the clock after the length takes effect.
- R10: On each advance the serial output takes the value that register bit length-1 had just before that advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Allows advancing |
| step_mode | input | 1 | 0 continuous, 1 single-step |
| step_strobe | input | 1 | Single-step pulse, rising edge advances |
| galois_sel | input | 1 | 0 shift-then-feed form, 1 shift-then-xor form |
| len_cfg | input | 7 | Requested register length |
| poly_load | input | 1 | Load tap word |
| poly_dflt | input | 1 | Load the default tap word instead of `poly_in` |
| poly_in | input | 64 | User tap word |
| seed_load | input | 1 | Load seed into the register |
| seed_dflt | input | 1 | Load the default seed instead of `seed_in` |
| seed_in | input | 64 | User seed |
| state_out | output | 64 | Current register contents |
| bit_out | output | 1 | Bit emitted by the last advance |

## Verification
Two maximal-length 4-bit tap words, one for each form, are run until the register returns to its seed. A period of exactly 15 separates a correct feedback network from a wrong tap order or a wrong shift direction. Random mixes of length, tap word, seed, form, mode and strobe are then compared cycle by cycle against a bench model. These runs expose wrong priorities between loading and advancing, and tap-word timing errors. Directed sequences cover a strobe held high, a disabled register under a toggling strobe, zero and out-of-range seeds, and lengths below 2 and above the maximum.

// File: rtl/lfsr_seq_pkg.sv
// Package: shared types for the linear feedback sequence generator.
// Assumes: nothing beyond IEEE 1800-2017.
package lfsr_seq_pkg;

    // Feedback arrangement of the register.
    typedef enum logic {
        TOPO_FIB = 1'b0,   // parity of taps shifted into bit 0
        TOPO_GAL = 1'b1    // taps xored in when the top bit leaves
    } topo_e;

    localparam int unsigned MIN_LEN = 2;

endpackage

// File: rtl/lfsr_seq_cfg.sv
// Module: lfsr_seq_cfg
// Holds the tap word and derives the active-length mask and the one-hot
// marker of the top active bit from the requested length.
// Assumes: len_cfg is wide enough to express MAX_W; values outside
// MIN_LEN..MAX_W are clamped.
module lfsr_seq_cfg #(
    parameter int unsigned MAX_W     = 64,
    parameter logic [MAX_W-1:0] DFLT_POLY = '0,
    localparam int unsigned LEN_W    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_cfg,
    input  logic             poly_load,
    input  logic             poly_dflt,
    input  logic [MAX_W-1:0] poly_in,
    output logic [MAX_W-1:0] poly_q,
    output logic [MAX_W-1:0] mask,
    output logic [MAX_W-1:0] top_sel
);
    import lfsr_seq_pkg::*;

    logic [LEN_W-1:0] len_eff;

    // Clamp the requested length into the supported range.
    always_comb begin
        if (len_cfg < LEN_W'(MIN_LEN))
            len_eff = LEN_W'(MIN_LEN);
        else if (len_cfg > LEN_W'(MAX_W))
            len_eff = LEN_W'(MAX_W);
        else
            len_eff = len_cfg;
    end

    // Per-bit active mask and top-bit marker.
    for (genvar i = 0; i < MAX_W; i++) begin : g_bit
        assign mask[i]    = (len_eff > LEN_W'(i));
        assign top_sel[i] = (len_eff == LEN_W'(i + 1));
    end

    // Tap word register: default on reset, replaced on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            poly_q <= DFLT_POLY;
        else if (poly_load)
            poly_q <= poly_dflt ? DFLT_POLY : poly_in;
    end

    // R8: without a load the tap word is kept.
    p_poly_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !poly_load |=> $stable(poly_q));

    // R9: exactly one top-bit marker, lying inside the mask.
    p_top_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(top_sel) == 1) && ((top_sel & ~mask) == '0));

endmodule

// File: rtl/lfsr_seq_pace.sv
// Module: lfsr_seq_pace
// Decides in which cycles the register advances: every enabled cycle in
// continuous mode, or once per rising strobe edge in single-step mode.
// Assumes: step_strobe is synchronous to clk.
module lfsr_seq_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step_mode,
    input  logic step_strobe,
    output logic adv
);
    logic strb_q;
    logic strb_rise;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strb_q <= 1'b0;
        else
            strb_q <= step_strobe;
    end

    // Advance decision for the current cycle.
    always_comb begin
        strb_rise = step_strobe & ~strb_q;
        adv       = en & (step_mode ? strb_rise : 1'b1);
    end

    // R6: in single-step mode two advances are never back to back.
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && step_mode) |=> !(adv && step_mode));

    // R5: no advance while disabled.
    p_no_adv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !adv);

endmodule

// File: rtl/lfsr_seq_core.sv
// Module: lfsr_seq_core
// The shift register itself: seed loading with zero replacement, the two
// feedback forms, masking to the active length and the serial output.
// Assumes: mask is contiguous from bit 0 and top_sel marks its top bit.
module lfsr_seq_core #(
    parameter int unsigned MAX_W     = 64,
    parameter logic [MAX_W-1:0] DFLT_SEED = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  lfsr_seq_pkg::topo_e topo,
    input  logic                seed_load,
    input  logic                seed_dflt,
    input  logic [MAX_W-1:0]    seed_in,
    input  logic [MAX_W-1:0]    poly,
    input  logic [MAX_W-1:0]    mask,
    input  logic [MAX_W-1:0]    top_sel,
    output logic [MAX_W-1:0]    state_q,
    output logic                bit_q
);
    import lfsr_seq_pkg::*;

    localparam logic [MAX_W-1:0] ONE = MAX_W'(1);

    logic [MAX_W-1:0] seed_src;
    logic [MAX_W-1:0] seed_msk;
    logic [MAX_W-1:0] seed_fix;
    logic [MAX_W-1:0] step_nxt;
    logic             msb;
    logic             fb;

    // Seed selection, masking and lock-up avoidance.
    always_comb begin
        seed_src = (!rst_n || seed_dflt) ? DFLT_SEED : seed_in;
        seed_msk = seed_src & mask;
        seed_fix = (seed_msk == '0) ? ONE : seed_msk;
    end

    // Next state for one advance under the selected feedback form.
    always_comb begin
        msb = |(state_q & top_sel);
        fb  = ^(state_q & poly & mask);
        if (topo == TOPO_GAL)
            step_nxt = ((state_q << 1) ^ ({MAX_W{msb}} & poly)) & mask;
        else
            step_nxt = ((state_q << 1) | {{(MAX_W-1){1'b0}}, fb}) & mask;
    end

    // Register update: reset, load, advance or hold (always masked).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= seed_fix;
            bit_q   <= 1'b0;
        end else if (seed_load) begin
            state_q <= seed_fix;
        end else if (adv) begin
            state_q <= step_nxt;
            bit_q   <= msb;
        end else begin
            state_q <= state_q & mask;
        end
    end

    // R9: no bit above the length that was active in the previous cycle.
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q & ~$past(mask)) == '0);

    // R7: a loaded register is never all zero.
    p_seed_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state_q != '0));

    // R5: with no advance, no load and an unchanged length, the state holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !seed_load && (mask == $past(mask))) |=> $stable(state_q) && $stable(bit_q));

    // R10: the serial bit is the top active bit before the advance.
    p_serial_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !seed_load) |=> (bit_q == $past(msb)));

endmodule

// File: rtl/lfsr_seq.sv
// Module: lfsr_seq (top)
// Programmable-length linear feedback sequence generator with run-time
// tap word, seed, feedback form and continuous or single-step pacing.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module lfsr_seq #(
    parameter int unsigned MAX_W = 64,
    parameter logic [MAX_W-1:0] DFLT_POLY = MAX_W'(64'hD800_0000_0000_0000),
    parameter logic [MAX_W-1:0] DFLT_SEED = MAX_W'(1),
    localparam int unsigned LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step_mode,
    input  logic             step_strobe,
    input  logic             galois_sel,
    input  logic [LEN_W-1:0] len_cfg,
    input  logic             poly_load,
    input  logic             poly_dflt,
    input  logic [MAX_W-1:0] poly_in,
    input  logic             seed_load,
    input  logic             seed_dflt,
    input  logic [MAX_W-1:0] seed_in,
    output logic [MAX_W-1:0] state_out,
    output logic             bit_out
);
    import lfsr_seq_pkg::*;

    logic [MAX_W-1:0] poly_q;
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] top_sel;
    logic             adv;
    topo_e            topo;

    assign topo = topo_e'(galois_sel);

    lfsr_seq_cfg #(
        .MAX_W     (MAX_W),
        .DFLT_POLY (DFLT_POLY)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_cfg   (len_cfg),
        .poly_load (poly_load),
        .poly_dflt (poly_dflt),
        .poly_in   (poly_in),
        .poly_q    (poly_q),
        .mask      (mask),
        .top_sel   (top_sel)
    );

    lfsr_seq_pace u_pace (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .step_mode   (step_mode),
        .step_strobe (step_strobe),
        .adv         (adv)
    );

    lfsr_seq_core #(
        .MAX_W     (MAX_W),
        .DFLT_SEED (DFLT_SEED)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .topo      (topo),
        .seed_load (seed_load),
        .seed_dflt (seed_dflt),
        .seed_in   (seed_in),
        .poly      (poly_q),
        .mask      (mask),
        .top_sel   (top_sel),
        .state_q   (state_out),
        .bit_q     (bit_out)
    );

endmodule

// File: tb/lfsr_seq_tb.sv
// Bench for lfsr_seq: directed corner cases plus seeded random stimulus,
// every cycle compared against a bench model built from the requirements.
module lfsr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] DFLT_POLY = 64'hD800_0000_0000_0000;
    localparam logic [63:0] DFLT_SEED = 64'd1;

    logic        clk = 1'b0;
    logic        rst_n, en, step_mode, step_strobe, galois_sel;
    logic [6:0]  len_cfg;
    logic        poly_load, poly_dflt, seed_load, seed_dflt;
    logic [63:0] poly_in, seed_in;
    logic [63:0] state_out;
    logic        bit_out;

    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] m_state, m_poly;
    logic        m_bit, m_strb;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .step_mode(step_mode),
        .step_strobe(step_strobe), .galois_sel(galois_sel), .len_cfg(len_cfg),
        .poly_load(poly_load), .poly_dflt(poly_dflt), .poly_in(poly_in),
        .seed_load(seed_load), .seed_dflt(seed_dflt), .seed_in(seed_in),
        .state_out(state_out), .bit_out(bit_out)
    );

    function automatic int clamp_len(int v);
        if (v < 2) return 2;
        if (v > 64) return 64;
        return v;
    endfunction

    function automatic logic [63:0] mask_of(int le);
        if (le >= 64) return '1;
        return (64'd1 << le) - 64'd1;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one clock; model predicts, then compare.
    task automatic tick(string tag);
        logic [63:0] msk, ns, sv, np;
        logic nb, ns_strb, rise, advm, msb;
        int le;
        le  = clamp_len(int'(len_cfg));
        msk = mask_of(le);
        if (!rst_n) begin
            sv = DFLT_SEED & msk;
            ns = (sv == 0) ? 64'd1 : sv;
            nb = 1'b0; np = DFLT_POLY; ns_strb = 1'b0;
        end else begin
            rise = step_strobe & ~m_strb;
            advm = en & (step_mode ? rise : 1'b1);
            msb  = m_state[le-1];
            nb   = m_bit;
            if (seed_load) begin
                sv = (seed_dflt ? DFLT_SEED : seed_in) & msk;
                ns = (sv == 0) ? 64'd1 : sv;
            end else if (advm) begin
                if (galois_sel)
                    ns = ((m_state << 1) ^ (msb ? m_poly : 64'd0)) & msk;
                else
                    ns = ((m_state << 1) | {63'd0, ^(m_state & m_poly & msk)}) & msk;
                nb = msb;
            end else begin
                ns = m_state & msk;
            end
            np = poly_load ? (poly_dflt ? DFLT_POLY : poly_in) : m_poly;
            ns_strb = step_strobe;
        end
        @(negedge clk);
        check({tag, " state"}, state_out, ns);
        check({tag, " bit"}, {63'd0, bit_out}, {63'd0, nb});
        m_state = ns; m_bit = nb; m_poly = np; m_strb = ns_strb;
    endtask

    task automatic idle();
        en = 0; step_mode = 0; step_strobe = 0; poly_load = 0; poly_dflt = 0;
        seed_load = 0; seed_dflt = 0; poly_in = 0; seed_in = 0;
    endtask

    // Load a tap word and seed together, register disabled.
    task automatic setup(logic gal, int len, logic [63:0] p, logic [63:0] s);
        idle();
        galois_sel = gal; len_cfg = 7'(len);
        poly_load = 1; poly_in = p; seed_load = 1; seed_in = s;
        tick("R7 R8 setup");
        idle();
    endtask

    // Run continuously until the seed returns; expect period 15.
    task automatic period_check(string tag);
        int per;
        per = 0;
        en = 1;
        for (int k = 1; k <= 20; k++) begin
            tick(tag);
            if (per == 0 && state_out == 64'd1) per = k;
        end
        en = 0;
        check({tag, " period"}, 64'(per), 64'd15);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] s0;
        void'($urandom(32'h5EED_1234));
        idle(); galois_sel = 0; len_cfg = 7'd16; rst_n = 0;
        m_state = 0; m_poly = 0; m_bit = 0; m_strb = 0;
        @(negedge clk);
        tick("R1 reset");
        tick("R1 reset");
        rst_n = 1;
        check("R1 reset state", state_out, 64'd1);
        check("R1 reset bit", {63'd0, bit_out}, 64'd0);

        // R2: shift-then-feed form, taps bits 3,2, length 4
        setup(1'b0, 4, 64'hC, 64'd1);
        period_check("R2 fib");
        // R3: shift-then-xor form, taps bits 1,0, length 4
        setup(1'b1, 4, 64'h3, 64'd1);
        period_check("R3 gal");

        // R4 R10: continuous run at length 64 with default taps
        idle(); galois_sel = 0; len_cfg = 7'd64; poly_load = 1; poly_dflt = 1;
        seed_load = 1; seed_in = 64'h8000_0000_0000_0001;
        tick("R8 default poly");
        idle(); en = 1;
        for (int k = 0; k < 20; k++) tick("R4 R10 continuous");

        // R5: disabled, strobe toggling in both modes
        idle(); s0 = state_out;
        for (int k = 0; k < 6; k++) begin
            step_mode = k[1]; step_strobe = k[0];
            tick("R5 disabled");
        end
        check("R5 hold", state_out, s0);

        // R6: strobe held high gives one advance
        idle(); step_mode = 1; en = 1; tick("R6 prep");
        s0 = state_out;
        step_strobe = 1; tick("R6 rise");
        check("R6 moved", {63'd0, state_out != s0}, 64'd1);
        s0 = state_out;
        for (int k = 0; k < 5; k++) tick("R6 held");
        check("R6 single", state_out, s0);
        step_strobe = 0; tick("R6 low");
        step_strobe = 1; tick("R6 second");

        // R7: zero seed, seed above length, load beats advance
        idle(); len_cfg = 7'd8; en = 1;
        seed_load = 1; seed_in = 64'd0; tick("R7 zero seed");
        check("R7 zero seed", state_out, 64'd1);
        seed_in = 64'hFF00; tick("R7 masked zero");
        check("R7 masked zero", state_out, 64'd1);
        seed_in = 64'h1A5; tick("R7 mask");
        check("R7 mask", state_out, 64'hA5);
        seed_dflt = 1; tick("R7 default seed");

        // R9: length below 2 and above maximum
        idle(); en = 1; len_cfg = 7'd1;
        for (int k = 0; k < 6; k++) tick("R9 short");
        check("R9 short upper", state_out & ~64'h3, 64'd0);
        len_cfg = 7'd100;
        for (int k = 0; k < 6; k++) tick("R9 long");

        // Random mix covering R2 R3 R4 R5 R6 R7 R8 R9 R10
        idle(); len_cfg = 7'd12; en = 1;
        for (int k = 0; k < 4000; k++) begin
            en          = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 49) == 0) step_mode = ~step_mode;
            if ($urandom_range(0, 49) == 0) galois_sel = ~galois_sel;
            if ($urandom_range(0, 59) == 0) len_cfg = 7'($urandom_range(0, 70));
            step_strobe = $urandom_range(0, 1) == 1;
            poly_load   = ($urandom_range(0, 39) == 0);
            poly_dflt   = ($urandom_range(0, 3) == 0);
            poly_in     = {$urandom, $urandom};
            seed_load   = ($urandom_range(0, 39) == 0);
            seed_dflt   = ($urandom_range(0, 3) == 0);
            seed_in     = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
            tick("R2 R3 R6 R7 R8 R9 R10 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule